// File: doc/BRIEF.md
# Software-Interrupt Entry Stacking Sequencer

This block carries out the entry part of two instructions of an 8-bit processor that has a 16-bit address space. The first is a software interrupt. The second is an instruction that clears condition-code bits and then waits for an interrupt. A pulse on `start` copies the processor registers into the block. The block then writes the whole machine state to the system stack, one byte per cycle, over a byte-wide memory port. It updates the condition-code byte as it goes, and afterwards either loads a new program counter from a fixed vector or parks until an interrupt request arrives.

Both modes use the same stacking path. In software-interrupt mode the block masks both interrupt levels after stacking, then reads the two vector bytes and loads them into the program counter. In wait mode it first fetches an immediate byte at the program counter and ANDs it into the condition codes. It then stacks the state, including the incremented program counter, and holds in a waiting state until `irq` goes high.

The condition-code byte uses these bit positions: bit 7 is the entire-state flag, bit 6 is the fast-interrupt mask and bit 4 is the normal interrupt mask. Memory reads are asynchronous: `mem_rdata` must be valid in the same cycle that `mem_rd` is high.

Top module: `swi_stack_seq`

## Requirements
- R1: While reset is high and after it is released, `busy`, `waiting`, `done`, `mem_wr` and `mem_rd` are low and `s_out`, `pc_out`, `cc_out` read zero. A read and a write are never issued in the same cycle.
- R2: The stack pointer is decremented once before the first stack write, so the first byte goes to address `s_in - 1`. Addresses wrap modulo 2^16.
- R3: Twelve bytes are written on consecutive cycles, each at an address one below the previous. The order is: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC. Each 16-bit register therefore has its high byte at the lower address.
- R4: The stacked CC byte has bit 7 (entire-state) set, and after stacking `s_out` equals `s_in - 12`, the address of the stacked CC.
- R5: In software-interrupt mode (`mode_wait`=0), after stacking `cc_out` has bits 6 and 4 set, and all other bits are as stacked.
- R6: In software-interrupt mode the block reads address 0xFFFA as the PC high byte, then 0xFFFB as the PC low byte. `pc_out` then holds that vector, and `done` rises 17 cycles after the `start` edge.
- R7: In wait mode (`mode_wait`=1) the block reads one byte at `pc_in` before stacking and ANDs it into CC. The stacked CC is `(cc_in & imm) | 0x80`, and the stacked PC is `pc_in + 1`.
- R8: In wait mode the block never reads the vector. After the last stack write it holds `waiting` high for as long as `irq` is low. One cycle after `irq` is sampled high it raises `done`, with `pc_out` = `pc_in + 1`.
- R9: `start` is ignored while `busy` is high. A pulse with different register inputs during a sequence does not change any stack byte or the final outputs.
- R10: `done` is a single-cycle pulse, and the block returns to idle (`busy` low) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence; sampled only when idle |
| mode_wait | input | 1 | 0 = software interrupt, 1 = clear-and-wait |
| irq | input | 1 | Interrupt request that ends the waiting state |
| pc_in | input | 16 | Program counter to stack |
| u_in | input | 16 | User stack pointer to stack |
| y_in | input | 16 | Index register Y to stack |
| x_in | input | 16 | Index register X to stack |
| s_in | input | 16 | System stack pointer at entry |
| dp_in | input | 8 | Direct-page register to stack |
| b_in | input | 8 | Accumulator B to stack |
| a_in | input | 8 | Accumulator A to stack |
| cc_in | input | 8 | Condition codes at entry |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_rd` is high |
| pc_out | output | 16 | Resulting program counter |
| s_out | output | 16 | Resulting system stack pointer |
| cc_out | output | 8 | Resulting condition codes |
| busy | output | 1 | Sequence in progress |
| waiting | output | 1 | Parked waiting for `irq` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the environment:
- `mem_rdata` is valid in the same cycle that `mem_rd` is high.
- The register inputs matter only in the cycle in which `start` is accepted.
- `irq` matters only while the block is waiting.

The bench's memory model returns the vector and immediate bytes combinationally from the address. It changes inputs only at falling edges and raises `irq` only after it has seen `waiting`. It also deliberately toggles `start` and the register inputs in the middle of a sequence, to show that the design tolerates it.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int CC_E_BIT   = 7;
  localparam int CC_F_BIT   = 6;
  localparam int CC_I_BIT   = 4;
  localparam int PUSH_BYTES = 12;
  localparam int STEP_W     = $clog2(PUSH_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IMM,
    ST_MARK,
    ST_PUSH,
    ST_MASK,
    ST_VHI,
    ST_VLO,
    ST_WAIT,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/swi_seq_fsm.sv
module swi_seq_fsm
  import swi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_wait,
  input  logic              irq,
  output seq_state_t        state,
  output logic [STEP_W-1:0] step,
  output logic              mode_q
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PUSH_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      step   <= '0;
      mode_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode_wait;
          state  <= mode_wait ? ST_IMM : ST_MARK;
        end
        ST_IMM:  state <= ST_MARK;
        ST_MARK: begin
          step  <= '0;
          state <= ST_PUSH;
        end
        ST_PUSH: begin
          if (step == LAST_STEP) state <= mode_q ? ST_WAIT : ST_MASK;
          else                   step  <= step + 1'b1;
        end
        ST_MASK: state <= ST_VHI;
        ST_VHI:  state <= ST_VLO;
        ST_VLO:  state <= ST_DONE;
        ST_WAIT: if (irq) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: without a request the waiting state persists
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !irq) |=> (state == ST_WAIT));

  // R3: step counter never leaves the push range
  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUSH) |-> (step <= LAST_STEP));

  // R9: a start seen mid-sequence does not restart it
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PUSH && start) |=> (state != ST_IMM && state != ST_MARK));
endmodule

// File: rtl/swi_push_mux.sv
module swi_push_mux
  import swi_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     u,
  input  logic [AW-1:0]     y,
  input  logic [AW-1:0]     x,
  input  logic [DW-1:0]     dp,
  input  logic [DW-1:0]     b,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     cc,
  input  logic [STEP_W-1:0] step,
  output logic [DW-1:0]     byte_out
);
  localparam int NWORDS = 4;

  logic [AW-1:0] words [NWORDS];
  logic [DW-1:0] bytes [PUSH_BYTES];

  assign words[0] = pc;
  assign words[1] = u;
  assign words[2] = y;
  assign words[3] = x;

  // low byte first, then high byte, for each word
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign bytes[2*k]   = words[k][DW-1:0];
    assign bytes[2*k+1] = words[k][AW-1:DW];
  end

  assign bytes[2*NWORDS]   = dp;
  assign bytes[2*NWORDS+1] = b;
  assign bytes[2*NWORDS+2] = a;
  assign bytes[2*NWORDS+3] = cc;

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < PUSH_BYTES; i++)
      if (step == STEP_W'(i)) byte_out = bytes[i];
  end
endmodule

// File: rtl/swi_stack_seq.sv
module swi_stack_seq
  import swi_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] VEC_ADDR = 16'hFFFA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_wait,
  input  logic          irq,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] u_in,
  input  logic [AW-1:0] y_in,
  input  logic [AW-1:0] x_in,
  input  logic [AW-1:0] s_in,
  input  logic [DW-1:0] dp_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] cc_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] s_out,
  output logic [DW-1:0] cc_out,
  output logic          busy,
  output logic          waiting,
  output logic          done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PUSH_BYTES - 1);
  localparam logic [AW-1:0]     VEC_HI_A  = AW'(VEC_ADDR);
  localparam logic [AW-1:0]     VEC_LO_A  = AW'(VEC_ADDR) + AW'(1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              mode_q;
  logic [DW-1:0]     push_byte;

  logic [AW-1:0] pc_q, u_q, y_q, x_q, s_q;
  logic [DW-1:0] dp_q, b_q, a_q, cc_q;

  swi_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode_wait (mode_wait),
    .irq       (irq),
    .state     (state),
    .step      (step),
    .mode_q    (mode_q)
  );

  swi_push_mux #(.AW(AW), .DW(DW)) u_mux (
    .pc       (pc_q),
    .u        (u_q),
    .y        (y_q),
    .x        (x_q),
    .dp       (dp_q),
    .b        (b_q),
    .a        (a_q),
    .cc       (cc_q),
    .step     (step),
    .byte_out (push_byte)
  );

  // register copy and update
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; u_q <= '0; y_q <= '0; x_q <= '0; s_q <= '0;
      dp_q <= '0; b_q <= '0; a_q <= '0; cc_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pc_q <= pc_in; u_q <= u_in; y_q <= y_in; x_q <= x_in; s_q <= s_in;
          dp_q <= dp_in; b_q <= b_in; a_q <= a_in; cc_q <= cc_in;
        end
        ST_IMM: begin
          cc_q <= cc_q & mem_rdata;
          pc_q <= pc_q + AW'(1);
        end
        ST_MARK: begin
          cc_q[CC_E_BIT] <= 1'b1;
          s_q            <= s_q - AW'(1);
        end
        ST_PUSH: if (step != LAST_STEP) s_q <= s_q - AW'(1);
        ST_MASK: begin
          cc_q[CC_I_BIT] <= 1'b1;
          cc_q[CC_F_BIT] <= 1'b1;
        end
        ST_VHI:  pc_q[AW-1:DW] <= mem_rdata;
        ST_VLO:  pc_q[DW-1:0]  <= mem_rdata;
        default: ;
      endcase
    end
  end

  // bus drive from registered state
  always_comb begin
    mem_addr  = '0;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_wdata = '0;
    case (state)
      ST_IMM:  begin mem_rd = 1'b1; mem_addr = pc_q; end
      ST_PUSH: begin mem_wr = 1'b1; mem_addr = s_q; mem_wdata = push_byte; end
      ST_VHI:  begin mem_rd = 1'b1; mem_addr = VEC_HI_A; end
      ST_VLO:  begin mem_rd = 1'b1; mem_addr = VEC_LO_A; end
      default: ;
    endcase
  end

  assign pc_out  = pc_q;
  assign s_out   = s_q;
  assign cc_out  = cc_q;
  assign busy    = (state != ST_IDLE);
  assign waiting = (state == ST_WAIT);
  assign done    = (state == ST_DONE);

  // R1: never read and write together
  p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));

  // R3: back-to-back writes walk downward one byte at a time
  p_push_down_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  // R4: the last stacked byte carries the entire-state flag
  p_cc_e_set_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && step == LAST_STEP) |-> mem_wdata[CC_E_BIT]);

  // R5: software interrupt finishes with both masks set
  p_masks_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !mode_q) |-> (cc_out[CC_I_BIT] && cc_out[CC_F_BIT]));

  // R8: wait mode never touches the vector
  p_no_vec_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q && busy && mem_rd) |-> (mem_addr != VEC_HI_A && mem_addr != VEC_LO_A));

  // R10: done lasts a single cycle and is followed by idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
endmodule

// File: tb/sim_swi_stack_seq.sv
module sim_swi_stack_seq;
  typedef struct packed {
    logic        mode;
    logic [15:0] pc, u, y, x, s;
    logic [7:0]  dp, b, a, cc, imm, vh, vl;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h8000, 8'h11, 8'h22, 8'h33, 8'h05, 8'h00, 8'hC1, 8'h2E},
    '{1'b0, 16'hFFFE, 16'h0101, 16'h0202, 16'h0303, 16'h0004, 8'hAA, 8'hBB, 8'hCC, 8'h2F, 8'h00, 8'h00, 8'h00},
    '{1'b1, 16'h4000, 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'h2000, 8'h01, 8'h02, 8'h03, 8'hFF, 8'hAF, 8'hEE, 8'hEE},
    '{1'b1, 16'hFFFF, 16'h1111, 16'h2222, 16'h3333, 16'h0100, 8'h44, 8'h55, 8'h66, 8'h1A, 8'h0F, 8'h99, 8'h99}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mode_wait = 1'b0, irq = 1'b0;
  logic [15:0] pc_in = '0, u_in = '0, y_in = '0, x_in = '0, s_in = '0;
  logic [7:0]  dp_in = '0, b_in = '0, a_in = '0, cc_in = '0;
  logic [15:0] mem_addr, pc_out, s_out;
  logic        mem_wr, mem_rd, busy, waiting, done;
  logic [7:0]  mem_wdata, mem_rdata, cc_out;
  logic [7:0]  m_imm = '0, m_vh = '0, m_vl = '0;
  logic [15:0] m_pc = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // memory model: vector and immediate bytes, asynchronous read
  assign mem_rdata = (mem_addr == 16'hFFFA) ? m_vh :
                     (mem_addr == 16'hFFFB) ? m_vl :
                     (mem_addr == m_pc)     ? m_imm : 8'h00;

  swi_stack_seq u0 (
    .clk(clk), .rst(rst), .start(start), .mode_wait(mode_wait), .irq(irq),
    .pc_in(pc_in), .u_in(u_in), .y_in(y_in), .x_in(x_in), .s_in(s_in),
    .dp_in(dp_in), .b_in(b_in), .a_in(a_in), .cc_in(cc_in),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .s_out(s_out), .cc_out(cc_out),
    .busy(busy), .waiting(waiting), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input vec_t v, input int k);
    logic [15:0] pcs;
    logic [7:0]  ccs;
    pcs = v.mode ? v.pc + 16'd1 : v.pc;
    ccs = (v.mode ? (v.cc & v.imm) : v.cc) | 8'h80;
    case (k)
      0: return pcs[7:0];  1: return pcs[15:8];
      2: return v.u[7:0];  3: return v.u[15:8];
      4: return v.y[7:0];  5: return v.y[15:8];
      6: return v.x[7:0];  7: return v.x[15:8];
      8: return v.dp;      9: return v.b;
      10: return v.a;      default: return ccs;
    endcase
  endfunction

  // run one sequence; extra_wait holds irq low that many cycles in wait mode,
  // disturb pulses start with other inputs mid-sequence
  task automatic run(input vec_t v, input int extra_wait, input bit disturb);
    int n = 0;
    int nw = 0;
    int held = 0;
    int done_at = 0;
    bit vec_read = 1'b0;
    logic [15:0] exp_cc16;
    logic [7:0]  ccs;
    ccs = (v.mode ? (v.cc & v.imm) : v.cc) | 8'h80;
    m_imm = v.imm; m_vh = v.vh; m_vl = v.vl; m_pc = v.pc;
    @(negedge clk);
    mode_wait = v.mode; pc_in = v.pc; u_in = v.u; y_in = v.y; x_in = v.x;
    s_in = v.s; dp_in = v.dp; b_in = v.b; a_in = v.a; cc_in = v.cc;
    start = 1'b1; irq = 1'b0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (disturb && n == 5) begin
        start = 1'b1; mode_wait = ~v.mode; s_in = 16'h7777; cc_in = 8'h00; pc_in = 16'h0BAD;
      end
      if (mem_wr) begin
        chk(mem_addr == v.s - 16'(nw + 1), "R2/R3 addr", 32'(mem_addr), 32'(v.s - 16'(nw + 1)));
        chk(mem_wdata == exp_byte(v, nw), nw == 11 ? "R4 stacked cc" : "R3 data",
            32'(mem_wdata), 32'(exp_byte(v, nw)));
        nw++;
      end
      if (mem_rd && (mem_addr == 16'hFFFA || mem_addr == 16'hFFFB)) vec_read = 1'b1;
      if (waiting) begin
        if (held < extra_wait) held++;
        else irq = 1'b1;
      end
      if (done) done_at = n;
    end while (!done && n < 200);
    irq = 1'b0;
    chk(done, "R10 done seen", 32'(done), 32'd1);
    chk(nw == 12, "R3 write count", 32'(nw), 32'd12);
    chk(s_out == v.s - 16'd12, "R4 final s", 32'(s_out), 32'(v.s - 16'd12));
    if (!v.mode) begin
      exp_cc16 = {8'h00, ccs | 8'h50};
      chk(cc_out == exp_cc16[7:0], "R5 cc masks", 32'(cc_out), 32'(exp_cc16));
      chk(pc_out == {v.vh, v.vl}, "R6 vector pc", 32'(pc_out), 32'({v.vh, v.vl}));
      chk(done_at == 17, "R6 latency", 32'(done_at), 32'd17);
    end else begin
      chk(cc_out == ccs, "R7 cc and", 32'(cc_out), 32'(ccs));
      chk(pc_out == v.pc + 16'd1, "R8 pc after wait", 32'(pc_out), 32'(v.pc + 16'd1));
      chk(!vec_read, "R8 no vector read", 32'(vec_read), 32'd0);
      chk(held == extra_wait, "R8 waiting held", 32'(held), 32'(extra_wait));
      chk(done_at == 16 + extra_wait, "R8 latency", 32'(done_at), 32'(16 + extra_wait));
    end
    @(negedge clk);
    chk(!done && !busy, "R10 pulse and idle", 32'({done, busy}), 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, while held and after release
    chk(!busy && !waiting && !done && !mem_wr && !mem_rd, "R1 idle in reset",
        32'({busy, waiting, done, mem_wr, mem_rd}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_wr && !mem_rd && s_out == 16'h0 && pc_out == 16'h0 && cc_out == 8'h0,
        "R1 after release", 32'({busy, mem_wr, mem_rd, s_out}), 32'd0);

    for (int i = 0; i < NV; i++) run(VECS[i], 0, 1'b0);

    // R8: long wait with irq held low
    run(VECS[2], 6, 1'b0);
    // R9: start pulse with other inputs during a software-interrupt sequence
    run(VECS[0], 0, 1'b1);
    // R9: same during a wait sequence
    run(VECS[3], 2, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule